// File: doc/BRIEF.md
# Two-State Difference-Metric Sequence Detector for a 1-D Channel

This block performs maximum-likelihood sequence detection for a channel whose noiseless output is the current binary symbol minus the previous one. The ideal received levels are therefore +a, 0 and -a. The trellis has two states: state 0 and state 1, each named after the previous input bit.

The block does not keep two absolute path metrics. It stores one signed value: metric 0 minus metric 1. On each accepted sample y, it builds a window from y - a/2 to y + a/2. If the stored difference lies above the window, it is clamped to the upper edge. If it lies below, it is clamped to the lower edge. Otherwise it is left alone. The clamp direction is the path decision: clamped from above, both survivors come from state 1; clamped from below, both come from state 0; untouched, each state extends its own path.

Each cycle the block emits a 2-bit decision code with a valid strobe, for a separate path memory to consume. It also exposes the stored difference.

Top module: `dicode_dm_detector`

## Requirements
- R1: A synchronous active-high reset sets the stored difference to 0, the decision code to 00 and the decision strobe to 0.
- R2: When the stored difference is strictly greater than y + a/2, the decision code is 10 (merge from state 1) and the new difference equals y + a/2.
- R3: When the stored difference is strictly less than y - a/2, the decision code is 01 (merge from state 0) and the new difference equals y - a/2.
- R4: When y - a/2 <= difference <= y + a/2, including both equalities, the decision code is 00 (hold) and the difference is unchanged. Code 11 never appears.
- R5: The decision strobe is high in exactly the cycle after a cycle with the input valid high. Code and difference for that sample are visible in the same cycle.
- R6: A cycle with the input valid low leaves the stored difference unchanged and drives the decision strobe low, whatever the sample value.
- R7: The difference register is one bit wider than the two's-complement sample, so clamping to the window for the extreme samples -2^(W-1) and 2^(W-1)-1 never wraps, for a/2 <= 2^(W-1).
- R8: After every accepted sample, the stored difference lies inside the window [y - a/2, y + a/2] of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | SAMPLE_W | Two's-complement equalized sample |
| dec_valid | output | 1 | Decision strobe, one cycle after in_valid |
| dec_code | output | 2 | 00 hold, 01 merge from state 0, 10 merge from state 1 |
| metric_diff | output | SAMPLE_W+1 | Stored difference metric, two's complement |

## Verification
A wrong stored difference shows up at the ports within one accepted sample. metric_diff is compared against the value expected after every sample. A wrong difference also sends a later sample to the wrong side of its window, so the decision code goes wrong on the first sample whose window separates the correct and incorrect values. The sequences therefore include samples that land exactly on both window edges, and samples at both extremes of the sample range. Off-by-one comparisons and missing sign extension are both caught in the cycle after the sample that exposes them.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD  = 2'b00,
    DEC_FROM0 = 2'b01,
    DEC_FROM1 = 2'b10
  } dec_e;
endpackage

// File: rtl/dmv_window.sv
// Builds the acceptance window [y - a/2, y + a/2] at the widened metric width.
module dmv_window #(
  parameter int SAMPLE_W = 6,
  parameter int LEVEL_A  = 16
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SAMPLE_W:0]   win_hi,
  output logic signed [SAMPLE_W:0]   win_lo
);
  localparam int DM_W = SAMPLE_W + 1;
  localparam logic signed [DM_W-1:0] HALF = DM_W'(LEVEL_A / 2);

  logic signed [DM_W-1:0] y_ext;

  always_comb begin
    y_ext  = {sample[SAMPLE_W-1], sample};
    win_hi = y_ext + HALF;
    win_lo = y_ext - HALF;
  end

  // R7: the upper edge never drops below the lower edge (no wrap)
  always_comb begin
    assert_no_overflow_R7: assert (win_hi >= win_lo);
  end
endmodule

// File: rtl/dmv_slicer.sv
// Adjustable-threshold slicer: clamps the stored difference into the window;
// the clamp direction is the path decision.
module dmv_slicer
  import dmv_pkg::*;
#(
  parameter int DM_W = 7
) (
  input  logic signed [DM_W-1:0] dm_prev,
  input  logic signed [DM_W-1:0] win_hi,
  input  logic signed [DM_W-1:0] win_lo,
  output dec_e                   dec,
  output logic signed [DM_W-1:0] dm_next
);
  logic above, below;

  always_comb begin
    above = dm_prev > win_hi;
    below = dm_prev < win_lo;
    if (above) begin
      dec     = DEC_FROM1;
      dm_next = win_hi;
    end else if (below) begin
      dec     = DEC_FROM0;
      dm_next = win_lo;
    end else begin
      dec     = DEC_HOLD;
      dm_next = dm_prev;
    end
  end

  // R4: both comparators firing at once would mean an inverted window
  always_comb begin
    assert_no_dual_merge_R4: assert (!(above && below));
  end
endmodule

// File: rtl/dmv_metric_reg.sv
// Holds the single difference metric.
module dmv_metric_reg #(
  parameter int DM_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [DM_W-1:0] dm_next,
  output logic signed [DM_W-1:0] dm_q
);
  always_ff @(posedge clk) begin
    if (rst)       dm_q <= '0;
    else if (load) dm_q <= dm_next;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> dm_q == '0);
  assert_metric_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dm_q));
endmodule

// File: rtl/dicode_dm_detector.sv
module dicode_dm_detector
  import dmv_pkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int LEVEL_A  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       dec_valid,
  output logic [1:0]                 dec_code,
  output logic signed [SAMPLE_W:0]   metric_diff
);
  localparam int DM_W = SAMPLE_W + 1;

  logic signed [DM_W-1:0] win_hi, win_lo, dm_next, dm_q;
  dec_e dec;

  dmv_window #(.SAMPLE_W(SAMPLE_W), .LEVEL_A(LEVEL_A)) u_win (
    .sample(in_sample), .win_hi(win_hi), .win_lo(win_lo)
  );

  dmv_slicer #(.DM_W(DM_W)) u_slc (
    .dm_prev(dm_q), .win_hi(win_hi), .win_lo(win_lo),
    .dec(dec), .dm_next(dm_next)
  );

  dmv_metric_reg #(.DM_W(DM_W)) u_dm (
    .clk(clk), .rst(rst), .load(in_valid), .dm_next(dm_next), .dm_q(dm_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_code  <= DEC_HOLD;
    end else begin
      dec_valid <= in_valid;
      if (in_valid) dec_code <= dec;
    end
  end

  assign metric_diff = dm_q;

  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> !dec_valid && dec_code == DEC_HOLD);
  assert_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> dec_valid);
  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !dec_valid);
  assert_merge1_R2: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_code == DEC_FROM1 |-> metric_diff == $past(win_hi));
  assert_merge0_R3: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_code == DEC_FROM0 |-> metric_diff == $past(win_lo));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_code == DEC_HOLD |-> metric_diff == $past(metric_diff));
  assert_code_legal_R4: assert property (@(posedge clk) disable iff (rst)
    dec_code != 2'b11);
  assert_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> metric_diff <= $past(win_hi) && metric_diff >= $past(win_lo));
endmodule

// File: tb/sim_dicode_dm_detector.sv
module sim_dicode_dm_detector;
  localparam int SW = 6;
  localparam int LA = 16;
  localparam int NV = 12;
  // sample, expected code, expected difference (a/2 = 8)
  localparam int T_Y [NV] = '{6, 10, -12, 0, 4, -12, 31, -32, -32, 31, 16, -16};
  localparam int T_C [NV] = '{0, 1, 2, 0, 0, 0, 1, 2, 0, 1, 0, 2};
  localparam int T_D [NV] = '{0, 2, -4, -4, -4, -4, 23, -24, -24, 23, 23, -8};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic dec_valid;
  logic [1:0] dec_code;
  logic signed [SW:0] metric_diff;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dicode_dm_detector #(.SAMPLE_W(SW), .LEVEL_A(LA)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .dec_valid(dec_valid), .dec_code(dec_code), .metric_diff(metric_diff)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge; outputs are examined at the next falling edge
  task automatic apply(input bit v, input int y);
    in_valid  = v;
    in_sample = SW'(y);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 metric", int'(metric_diff), 0);
    check("R1 strobe", int'(dec_valid), 0);
    check("R1 code", int'(dec_code), 0);
    rst = 1'b0;
    @(negedge clk);

    // Vector walk: R2 code 10, R3 code 01, R4 code 00 (edges inclusive),
    // R7 at extreme samples 31/-32, R5 strobe per sample.
    for (int i = 0; i < NV; i++) begin
      string tag;
      apply(1'b1, T_Y[i]);
      tag = (T_C[i] == 2) ? "R2" : (T_C[i] == 1) ? "R3" : "R4";
      if (i >= 6 && i <= 9) tag = {tag, "/R7"};
      check({tag, " code"}, int'(dec_code), T_C[i]);
      check({tag, " metric"}, int'(metric_diff), T_D[i]);
      check("R5 strobe", int'(dec_valid), 1);
      // R8: difference within window of this sample
      check("R8 window", int'(metric_diff >= T_Y[i] - LA/2 && metric_diff <= T_Y[i] + LA/2), 1);
    end

    // R6: invalid cycles with samples that would clamp are ignored
    apply(1'b0, 31);
    check("R6 strobe", int'(dec_valid), 0);
    check("R6 metric", int'(metric_diff), -8);
    apply(1'b0, -32);
    check("R6 metric", int'(metric_diff), -8);
    // R5: strobe returns one cycle after valid rises
    apply(1'b1, 0);
    check("R5 strobe", int'(dec_valid), 1);
    check("R4 hold at lower edge", int'(metric_diff), -8);

    // R1: mid-stream reset clears the metric
    rst = 1'b1;
    apply(1'b1, 31);
    check("R1 metric", int'(metric_diff), 0);
    check("R1 strobe", int'(dec_valid), 0);
    rst = 1'b0;
    // R4: zero metric exactly on upper, then lower edge
    apply(1'b1, -8);
    check("R4 upper edge code", int'(dec_code), 0);
    check("R4 upper edge metric", int'(metric_diff), 0);
    apply(1'b1, 8);
    check("R4 lower edge code", int'(dec_code), 0);
    check("R4 lower edge metric", int'(metric_diff), 0);
    // R3 then R2 directly after reset
    apply(1'b1, 9);
    check("R3 code", int'(dec_code), 1);
    check("R3 metric", int'(metric_diff), 1);
    apply(1'b1, -10);
    check("R2 code", int'(dec_code), 2);
    check("R2 metric", int'(metric_diff), -2);
    apply(1'b0, 0);
    check("R6 strobe", int'(dec_valid), 0);
    finish_run();
  end
endmodule